// File: doc/BRIEF.md
# Selectable-Phase IQ Sample Demultiplexer

This block turns a stream of IF samples, taken four times per IF period, into in-phase and quadrature values. Inside one period the samples carry the roles I, Q, −I, −Q in that repeating order. The block sorts each sample by its role and negates the samples that carry −I and −Q. It then averages the two estimates of each component and produces one I/Q pair per four-sample period. At the intended sample rate this is one pair per microsecond.

A 2-bit start-point input names the role of the first sample after a pulse trigger. Each step of the start point rotates the detected vector by 90 degrees. The start point is latched only at the trigger, so a pulse that is already running is never re-phased. Samples that arrive before the first trigger are ignored.

Top module: `iq_phase_demux`

## Requirements
- R1: While reset is active, and after it, until the first result: `out_vld` is 0 and `i_out` and `q_out` are 0.
- R2: Sample number k after a trigger (k = 0 is the sample accepted in the trigger cycle, or the first sample accepted after it) has the role (start + k) mod 4, with codes 0 = I, 1 = Q, 2 = −I, 3 = −Q. The result is `i_out` = floor((I + neg(−I))/2) and `q_out` = floor((Q + neg(−Q))/2), computed in two's complement.
- R3: For the same input samples, raising `start_sel` by one maps the result (I, Q) to (−Q, I), which is a 90-degree rotation.
- R4: The negation neg() saturates: the most negative input code becomes the most positive code.
- R5: `out_vld` is high for exactly one clock cycle for each complete group of four accepted samples. It rises at the rising edge that follows the edge accepting the fourth sample.
- R6: Samples presented before the first trigger after reset produce no result.
- R7: A change of `start_sel` without a trigger has no effect. Grouping and role order continue with the value latched at the last trigger.
- R8: A trigger in the middle of a group discards the partial group and starts a new group at the sample in the trigger cycle.
- R9: Cycles with `sample_vld` low between samples have no effect on grouping or on the result.
- R10: `i_out` and `q_out` hold their values between `out_vld` strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig | input | 1 | Pulse trigger, one cycle wide; latches `start_sel` and restarts grouping |
| start_sel | input | 2 | Role code of the first sample after a trigger |
| sample_vld | input | 1 | Qualifies `sample_in` |
| sample_in | input | SAMPLE_W | Signed IF sample |
| i_out | output | SAMPLE_W | Detected in-phase value |
| q_out | output | SAMPLE_W | Detected quadrature value |
| out_vld | output | 1 | One-cycle strobe per complete group |

## Verification
The bench builds the block with SAMPLE_W = 8. At that width the saturation corner (code −128 in a negated role) and the floor rounding of odd negative sums can be written as small hand-computed vectors. One set of samples is run with all four start points, which checks the 90-degree rotation directly. The directed tests then cover start-point changes without a trigger, a restart in the middle of a group, untriggered samples and idle gaps between samples.

// File: rtl/iqd_pkg.sv
package iqd_pkg;
  localparam int unsigned ROLE_CNT = 4;
  localparam int unsigned ROLE_W   = $clog2(ROLE_CNT);

  typedef enum logic [ROLE_W-1:0] {
    ROLE_I  = 2'd0,
    ROLE_Q  = 2'd1,
    ROLE_NI = 2'd2,
    ROLE_NQ = 2'd3
  } role_e;
endpackage

// File: rtl/iqd_phase_ctrl.sv
module iqd_phase_ctrl
  import iqd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [ROLE_W-1:0] start_sel,
  input  logic              sample_vld,
  output logic              take,
  output logic [ROLE_W-1:0] role,
  output logic              group_done
);
  localparam logic [ROLE_W-1:0] SLOT_LAST = ROLE_W'(ROLE_CNT - 1);

  logic              armed_q, armed_d;
  logic [ROLE_W-1:0] role_q, role_d;
  logic [ROLE_W-1:0] slot_q, slot_d, slot_eff;
  logic              done_q, done_d;

  always_comb begin
    armed_d  = armed_q | trig;
    role     = trig ? start_sel : role_q;
    slot_eff = trig ? '0 : slot_q;
    take     = sample_vld & armed_d;
    role_d   = take ? role + 1'b1 : role;
    slot_d   = take ? slot_eff + 1'b1 : slot_eff;
    done_d   = take & (slot_eff == SLOT_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      role_q  <= '0;
      slot_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      role_q  <= role_d;
      slot_q  <= slot_d;
      done_q  <= done_d;
    end
  end

  assign group_done = done_q;
endmodule

// File: rtl/iqd_role_store.sv
module iqd_role_store
  import iqd_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              take,
  input  logic [ROLE_W-1:0]                 role,
  input  logic signed [SAMPLE_W-1:0]        din,
  output logic [ROLE_CNT-1:0][SAMPLE_W-1:0] held
);
  localparam logic signed [SAMPLE_W-1:0] S_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic signed [SAMPLE_W-1:0] S_MAX = ~S_MIN;

  function automatic logic signed [SAMPLE_W-1:0] sat_neg(input logic signed [SAMPLE_W-1:0] x);
    if (x == S_MIN) return S_MAX;
    return -x;
  endfunction

  for (genvar r = 0; r < ROLE_CNT; r++) begin : g_role
    logic                      en;
    logic signed [SAMPLE_W-1:0] val;
    logic [SAMPLE_W-1:0]       q, d;

    // roles 2 and 3 carry the negated component
    if (r >= ROLE_CNT / 2) begin : g_neg
      assign val = sat_neg(din);
    end else begin : g_pos
      assign val = din;
    end

    always_comb begin
      en = take & (role == ROLE_W'(r));
      d  = en ? val : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign held[r] = q;
  end
endmodule

// File: rtl/iqd_combine.sv
module iqd_combine
  import iqd_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              group_done,
  input  logic [ROLE_CNT-1:0][SAMPLE_W-1:0] held,
  output logic signed [SAMPLE_W-1:0]        i_out,
  output logic signed [SAMPLE_W-1:0]        q_out,
  output logic                              out_vld
);
  function automatic logic [SAMPLE_W-1:0] half_sum(input logic [SAMPLE_W-1:0] a,
                                                   input logic [SAMPLE_W-1:0] b);
    logic [SAMPLE_W:0] s;
    s = {a[SAMPLE_W-1], a} + {b[SAMPLE_W-1], b};
    return s[SAMPLE_W:1];
  endfunction

  logic [SAMPLE_W-1:0] i_q, i_d, q_q, q_d;
  logic                vld_q, vld_d;

  always_comb begin
    vld_d = group_done;
    i_d   = group_done ? half_sum(held[ROLE_I], held[ROLE_NI]) : i_q;
    q_d   = group_done ? half_sum(held[ROLE_Q], held[ROLE_NQ]) : q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q   <= '0;
      q_q   <= '0;
      vld_q <= 1'b0;
    end else begin
      i_q   <= i_d;
      q_q   <= q_d;
      vld_q <= vld_d;
    end
  end

  assign i_out   = i_q;
  assign q_out   = q_q;
  assign out_vld = vld_q;
endmodule

// File: rtl/iq_phase_demux.sv
module iq_phase_demux
  import iqd_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       trig,
  input  logic [1:0]                 start_sel,
  input  logic                       sample_vld,
  input  logic signed [SAMPLE_W-1:0] sample_in,
  output logic signed [SAMPLE_W-1:0] i_out,
  output logic signed [SAMPLE_W-1:0] q_out,
  output logic                       out_vld
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic                              take, group_done;
  logic [ROLE_W-1:0]                 role;
  logic [ROLE_CNT-1:0][SAMPLE_W-1:0] held;

  iqd_phase_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .trig       (trig),
    .start_sel  (start_sel),
    .sample_vld (sample_vld),
    .take       (take),
    .role       (role),
    .group_done (group_done)
  );

  iqd_role_store #(.SAMPLE_W(SAMPLE_W)) u_store (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .take  (take),
    .role  (role),
    .din   (sample_in),
    .held  (held)
  );

  iqd_combine #(.SAMPLE_W(SAMPLE_W)) u_comb (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .group_done (group_done),
    .held       (held),
    .i_out      (i_out),
    .q_out      (q_out),
    .out_vld    (out_vld)
  );
endmodule

// File: rtl/iq_phase_demux_chk.sv
module iq_phase_demux_chk #(
  parameter int unsigned SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                trig,
  input logic                sample_vld,
  input logic [SAMPLE_W-1:0] i_out,
  input logic [SAMPLE_W-1:0] q_out,
  input logic                out_vld
);
  // independent count of accepted samples since the last trigger
  logic       seen_q;
  logic [1:0] cnt_q;
  logic       due_q;
  logic [1:0] slot;
  logic       acc;

  always_comb begin
    slot = trig ? 2'd0 : cnt_q;
    acc  = sample_vld & (trig | seen_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      cnt_q  <= 2'd0;
      due_q  <= 1'b0;
    end else begin
      seen_q <= seen_q | trig;
      cnt_q  <= acc ? slot + 2'd1 : slot;
      due_q  <= acc & (slot == 2'd3);
    end
  end

  assert_vld_due_R5: assert property (@(posedge clk) disable iff (!rst_n)
    due_q |=> out_vld);

  assert_vld_only_when_due_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(due_q));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> !out_vld);

  assert_no_untriggered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !out_vld);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> ($stable(i_out) && $stable(q_out)));
endmodule

bind iq_phase_demux iq_phase_demux_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .trig       (trig),
  .sample_vld (sample_vld),
  .i_out      (i_out),
  .q_out      (q_out),
  .out_vld    (out_vld)
);

// File: tb/iq_phase_demux_tb.sv
module iq_phase_demux_tb;
  localparam int W = 8;
  localparam time HALF = 10ns;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                trig = 1'b0;
  logic [1:0]          start_sel = 2'd0;
  logic                sample_vld = 1'b0;
  logic signed [W-1:0] sample_in = '0;
  logic signed [W-1:0] i_out, q_out;
  logic                out_vld;

  int n_chk = 0;
  int n_fail = 0;
  int pulses = 0;
  bit finished = 0;

  always #HALF clk = ~clk;

  iq_phase_demux #(.SAMPLE_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .start_sel(start_sel),
    .sample_vld(sample_vld), .sample_in(sample_in),
    .i_out(i_out), .q_out(q_out), .out_vld(out_vld)
  );

  always @(negedge clk) if (out_vld === 1'b1) pulses++;

  // {start, x0, x1, x2, x3, expected I, expected Q}
  localparam logic [49:0] VEC [8] = '{
    {2'd0, 8'h0A, 8'h14, 8'hE2, 8'h04, 8'h14, 8'h08},
    {2'd1, 8'h0A, 8'h14, 8'hE2, 8'h04, 8'hF8, 8'h14},
    {2'd2, 8'h0A, 8'h14, 8'hE2, 8'h04, 8'hEC, 8'hF8},
    {2'd3, 8'h0A, 8'h14, 8'hE2, 8'h04, 8'h08, 8'hEC},
    {2'd0, 8'h7F, 8'h00, 8'h80, 8'h00, 8'h7F, 8'h00},
    {2'd0, 8'h80, 8'h80, 8'h7F, 8'h7F, 8'h80, 8'h80},
    {2'd0, 8'h03, 8'hFF, 8'h00, 8'h00, 8'h01, 8'hFF},
    {2'd3, 8'h80, 8'h05, 8'h07, 8'h09, 8'hFE, 8'h43}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input bit t, input logic [W-1:0] x);
    trig = t;
    sample_vld = 1'b1;
    sample_in = x;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    trig = 1'b0;
    sample_vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int p0;
    logic signed [W-1:0] hi, hq;

    repeat (3) @(negedge clk);
    chk("R1 vld in reset", out_vld, 0);
    chk("R1 i in reset", i_out, 0);
    rst_n = 1'b1;
    idle(5);
    chk("R1 vld after reset", out_vld, 0);
    chk("R1 q after reset", q_out, 0);

    // R6: samples before any trigger
    for (int k = 0; k < 8; k++) push(1'b0, 8'h11);
    idle(3);
    chk("R6 no pulse untriggered", pulses, 0);
    chk("R6 i untouched", i_out, 0);

    // vector loop: R2, R3, R4, R5; odd entries have gaps (R9)
    for (int v = 0; v < 8; v++) begin
      logic [49:0] e;
      e = VEC[v];
      start_sel = e[49:48];
      p0 = pulses;
      for (int s = 0; s < 4; s++) begin
        push(s == 0, e[47 - 8*s -: 8]);
        if (v % 2 == 1 && s < 3) idle(2);
      end
      idle(1);
      chk($sformatf("R5 vld after fourth v%0d", v), out_vld, 1);
      chk($sformatf("R2 R3 R4 i v%0d (R9 gaps on odd)", v), int'(i_out), int'($signed(e[15:8])));
      chk($sformatf("R2 R3 R4 q v%0d", v), int'(q_out), int'($signed(e[7:0])));
      idle(1);
      chk($sformatf("R5 single pulse v%0d", v), pulses - p0, 1);
    end

    // R10: outputs hold between strobes
    hi = i_out; hq = q_out;
    idle(6);
    chk("R10 i held", int'(i_out), int'(hi));
    chk("R10 q held", int'(q_out), int'(hq));

    // R7: start_sel change without trigger keeps latched order
    start_sel = 2'd0;
    push(1'b1, 8'h0A); push(1'b0, 8'h14); push(1'b0, 8'hE2); push(1'b0, 8'h04);
    idle(2);
    start_sel = 2'd2;
    push(1'b0, 8'h0A); push(1'b0, 8'h14); push(1'b0, 8'hE2); push(1'b0, 8'h04);
    idle(1);
    chk("R7 vld", out_vld, 1);
    chk("R7 i keeps start 0", int'(i_out), 20);
    chk("R7 q keeps start 0", int'(q_out), 8);
    idle(1);
    push(1'b1, 8'h0A); push(1'b0, 8'h14); push(1'b0, 8'hE2); push(1'b0, 8'h04);
    idle(1);
    chk("R7 new start at trigger i", int'(i_out), -20);
    chk("R7 new start at trigger q", int'(q_out), -8);
    idle(1);

    // R8: restart mid-group discards partial group
    start_sel = 2'd0;
    p0 = pulses;
    push(1'b1, 8'h64); push(1'b0, 8'h64);
    push(1'b1, 8'h0A); push(1'b0, 8'h14); push(1'b0, 8'hE2); push(1'b0, 8'h04);
    idle(1);
    chk("R8 i after restart", int'(i_out), 20);
    chk("R8 q after restart", int'(q_out), 8);
    idle(2);
    chk("R8 one pulse only", pulses - p0, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule